// File: doc/BRIEF.md
# Single-Bus ALU Datapath

This block is the arithmetic core of a processor built around one shared internal bus. A control sequencer outside the block asserts per-register drive and load strobes each cycle. A register that drives places its contents on the bus, and a register that loads captures the bus at the next rising clock edge. The ALU has no storage of its own. Its A operand comes from a two-way multiplexer that selects either the Y staging register or the constant 4, which is used to step a program counter. Its B operand is the bus value in the current cycle. The ALU result reaches the rest of the datapath only after it has been captured in the Z register and Z has driven the bus in a later cycle.

A typical addition therefore takes three steps. In the first, the source register drives the bus and Y loads it. In the second, the other source drives the bus, Y is selected onto A, the add code is applied and Z loads the result. In the third, Z drives the bus and the destination register loads it. An immediate input acts as one more bus driver so that constants can be placed in the registers. An observation port reads any general register, and Y, Z and the bus value are brought out directly. When more than one driver is enabled, a conflict flag rises and a fixed priority decides which value the bus carries.

Top module: `sbus_datapath`

## Requirements
- R1: While rst_n is low at a rising edge, all eight general registers, Y and Z are cleared to 0 at that edge.
- R2: With exactly one driver enabled, bus_val equals that driver's value in the same cycle and bus_conflict is 0. With no driver enabled, bus_val is 0 and bus_conflict is 0.
- R3: With two or more drivers enabled, bus_conflict is 1 and bus_val takes the value of the lowest-numbered enabled driver. Drivers are numbered R0..R7 as 0..7, then Z as 8, then the immediate as 9.
- R4: A general register Rk whose load bit (bit k of reg_load_en) is set captures bus_val at the next rising edge. Registers whose load bit is clear keep their contents.
- R5: When y_load is 1, Y captures bus_val at the next edge. Otherwise Y holds its value.
- R6: When z_load is 1, Z captures the ALU result computed from the A operand and the current bus_val at the next edge. Otherwise Z holds its value.
- R7: When a_sel_const is 1, the A operand is the constant 4. When it is 0, the A operand is Y.
- R8: alu_op codes, with results taken modulo 2^16: 0 = A+B, 1 = A-B, 2 = A AND B, 3 = A OR B, 4 = A XOR B, 5 = B shifted left by one, 6 = B shifted right by one (logical), 7 = A.
- R9: The three-step sequence (stage into Y; add into Z; move Z to the destination) leaves the sum of the two sources in the destination register.
- R10: Driving Z back onto the bus in the same cycle that a general register drives operand B raises bus_conflict, and the bus carries the general register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_out_en | input | 8 | Bit k lets Rk drive the bus |
| reg_load_en | input | 8 | Bit k loads Rk from the bus |
| y_load | input | 1 | Load Y from the bus |
| z_load | input | 1 | Load Z from the ALU result |
| z_drive | input | 1 | Z drives the bus |
| a_sel_const | input | 1 | 1: A operand is constant 4; 0: A operand is Y |
| alu_op | input | 3 | ALU function code |
| imm_drive | input | 1 | Immediate drives the bus |
| imm_data | input | 16 | Immediate value |
| obs_sel | input | 3 | General register index to observe |
| obs_data | output | 16 | Contents of the selected register |
| y_val | output | 16 | Contents of Y |
| z_val | output | 16 | Contents of Z |
| bus_val | output | 16 | Current bus value |
| bus_conflict | output | 1 | More than one driver is enabled |

## Verification
The hardest situation to reach from the ports is a conflict between Z and a general register: Z must first hold a known, distinct value, and that value only gets into Z through an earlier ALU step. The vector table therefore builds up register contents through the normal three-step transfers, leaves a known value in Z with a pass-A operation, and only then enables several drivers at once. Every ALU code's result is made visible by a following vector that lets Z drive the bus.

// File: rtl/sbus_pkg.sv
// Package: shared widths, the ALU function encoding and the increment constant
// for the single-bus datapath. Assumes all parts include it before use.
package sbus_pkg;
    localparam int DATA_W   = 16;
    localparam int NUM_REGS = 8;
    localparam int OP_W     = 3;
    localparam int INC_CONST = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SHLB = 3'd5,
        OP_SHRB = 3'd6,
        OP_PASA = 3'd7
    } alu_op_e;
endpackage

// File: rtl/sbus_stage_reg.sv
// Module: one bus-side storage register with a load strobe.
// Assumes a synchronous active-low reset that takes priority over the load.
module sbus_stage_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture d when load is high; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/sbus_regfile.sv
// Module: N general registers, each loaded from the bus by its own strobe.
// Assumes several registers may load the same bus value in one cycle.
module sbus_regfile #(
    parameter int W = 16,
    parameter int N = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        load_en,
    input  logic [W-1:0]        bus_in,
    output logic [N-1:0][W-1:0] q
);
    // One storage register per index.
    for (genvar g = 0; g < N; g++) begin : g_reg
        sbus_stage_reg #(.W(W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load_en[g]),
            .d     (bus_in),
            .q     (q[g])
        );
    end
endmodule

// File: rtl/sbus_bus_arb.sv
// Module: resolves N bus drivers onto one bus. The lowest enabled index wins,
// an idle bus reads zero, and a flag marks more than one enabled driver.
// Assumes driver order is fixed by the caller.
module sbus_bus_arb #(
    parameter int W = 16,
    parameter int N = 10
) (
    input  logic [N-1:0]        drv_en,
    input  logic [N-1:0][W-1:0] drv_data,
    output logic [W-1:0]        bus,
    output logic                conflict
);
    localparam int CNT_W = $clog2(N + 1);

    logic [CNT_W-1:0] n_active;

    // Walk from the highest index down so that the lowest enabled index wins.
    always_comb begin
        bus = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (drv_en[i])
                bus = drv_data[i];
        end
    end

    // Count the enabled drivers for the conflict flag.
    always_comb begin
        n_active = '0;
        for (int i = 0; i < N; i++)
            n_active = n_active + CNT_W'(drv_en[i]);
    end

    assign conflict = (n_active > CNT_W'(1));
endmodule

// File: rtl/sbus_alu.sv
// Module: combinational ALU with no storage. A comes from the operand
// multiplexer and B from the bus. Results wrap modulo 2^W.
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    y
);
    // Select the function named by the operation code.
    always_comb begin
        unique case (alu_op_e'(op))
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SHLB: y = {b[W-2:0], 1'b0};
            OP_SHRB: y = {1'b0, b[W-1:1]};
            default: y = a;
        endcase
    end
endmodule

// File: rtl/sbus_datapath.sv
// Module: single-bus datapath top. It holds the general registers, the Y
// staging register, the A-operand multiplexer (Y or constant 4), the ALU and
// the Z result register. Driver order for bus priority: R0..R7, Z, immediate.
// Assumes a sequencer outside the block drives every strobe each cycle.
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int NREG  = NUM_REGS,
    parameter int KCONST = INC_CONST
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          reg_out_en,
    input  logic [NREG-1:0]          reg_load_en,
    input  logic                     y_load,
    input  logic                     z_load,
    input  logic                     z_drive,
    input  logic                     a_sel_const,
    input  logic [OP_W-1:0]          alu_op,
    input  logic                     imm_drive,
    input  logic [W-1:0]             imm_data,
    input  logic [$clog2(NREG)-1:0]  obs_sel,
    output logic [W-1:0]             obs_data,
    output logic [W-1:0]             y_val,
    output logic [W-1:0]             z_val,
    output logic [W-1:0]             bus_val,
    output logic                     bus_conflict
);
    localparam int NDRV  = NREG + 2;
    localparam int Z_IDX = NREG;
    localparam int I_IDX = NREG + 1;

    logic [NREG-1:0][W-1:0] rf_q;
    logic [NDRV-1:0]        drv_en;
    logic [NDRV-1:0][W-1:0] drv_data;
    logic [W-1:0]           a_opnd;
    logic [W-1:0]           alu_res;

    // General register file.
    sbus_regfile #(.W(W), .N(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (reg_load_en),
        .bus_in  (bus_val),
        .q       (rf_q)
    );

    // Y stages operand A from the bus.
    sbus_stage_reg #(.W(W)) u_y (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (y_load),
        .d     (bus_val),
        .q     (y_val)
    );

    // Z holds the ALU result until it drives the bus.
    sbus_stage_reg #(.W(W)) u_z (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (z_load),
        .d     (alu_res),
        .q     (z_val)
    );

    // Gather the general-register drivers in index order.
    for (genvar g = 0; g < NREG; g++) begin : g_drv
        assign drv_en[g]   = reg_out_en[g];
        assign drv_data[g] = rf_q[g];
    end
    assign drv_en[Z_IDX]   = z_drive;
    assign drv_data[Z_IDX] = z_val;
    assign drv_en[I_IDX]   = imm_drive;
    assign drv_data[I_IDX] = imm_data;

    // Resolve the shared bus.
    sbus_bus_arb #(.W(W), .N(NDRV)) u_arb (
        .drv_en   (drv_en),
        .drv_data (drv_data),
        .bus      (bus_val),
        .conflict (bus_conflict)
    );

    // Operand A multiplexer: constant increment or Y.
    assign a_opnd = a_sel_const ? W'(KCONST) : y_val;

    // Combinational ALU, B taken straight from the bus.
    sbus_alu #(.W(W)) u_alu (
        .op (alu_op),
        .a  (a_opnd),
        .b  (bus_val),
        .y  (alu_res)
    );

    assign obs_data = rf_q[obs_sel];
endmodule

// File: rtl/sbus_datapath_chk.sv
// Checker: temporal properties of the datapath, seen through its ports.
// Bound to every instance of sbus_datapath.
module sbus_datapath_chk #(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREG-1:0] reg_out_en,
    input logic            y_load,
    input logic            z_load,
    input logic            z_drive,
    input logic            a_sel_const,
    input logic [2:0]      alu_op,
    input logic            imm_drive,
    input logic [W-1:0]    y_val,
    input logic [W-1:0]    z_val,
    input logic [W-1:0]    bus_val,
    input logic            bus_conflict
);
    logic [W-1:0] sum_y;
    logic [W-1:0] sum_k;
    assign sum_y = y_val + bus_val;
    assign sum_k = W'(4) + bus_val;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (y_val == '0 && z_val == '0));

    p_idle_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_out_en == '0 && !z_drive && !imm_drive) |-> (bus_val == '0 && !bus_conflict));

    p_conflict_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_conflict == ($countones({imm_drive, z_drive, reg_out_en}) > 1));

    p_z_over_imm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_out_en == '0 && z_drive) |-> bus_val == z_val);

    p_y_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        y_load |=> y_val == $past(bus_val));

    p_y_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !y_load |=> $stable(y_val));

    p_z_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (z_load && !a_sel_const && alu_op == 3'd0) |=> z_val == $past(sum_y));

    p_z_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !z_load |=> $stable(z_val));

    p_const_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (z_load && a_sel_const && alu_op == 3'd0) |=> z_val == $past(sum_k));
endmodule

bind sbus_datapath sbus_datapath_chk #(.W(W), .NREG(NREG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_out_en   (reg_out_en),
    .y_load       (y_load),
    .z_load       (z_load),
    .z_drive      (z_drive),
    .a_sel_const  (a_sel_const),
    .alu_op       (alu_op),
    .imm_drive    (imm_drive),
    .y_val        (y_val),
    .z_val        (z_val),
    .bus_val      (bus_val),
    .bus_conflict (bus_conflict)
);

// File: tb/sbus_datapath_bench.sv
// Bench: a table of per-cycle control vectors with expected bus results,
// then directed checks of register contents, hold behaviour and reset.
module sbus_datapath_bench;
    typedef struct packed {
        logic [7:0]  ro;
        logic [7:0]  ri;
        logic        yi;
        logic        zi;
        logic        zo;
        logic        sc;
        logic [2:0]  op;
        logic        io;
        logic [15:0] imm;
        logic [15:0] ebus;
        logic        ec;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{8'h00, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 16'h1234, 16'h1234, 1'b0},
        '{8'h00, 8'h04, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 16'h0F0F, 16'h0F0F, 1'b0},
        '{8'h02, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h1234, 1'b0},
        '{8'h04, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h0F0F, 1'b0},
        '{8'h00, 8'h08, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h2143, 1'b0},
        '{8'h08, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h2143, 1'b0},
        '{8'h04, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 16'h0000, 16'h0F0F, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h0325, 1'b0},
        '{8'h04, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 16'h0000, 16'h0F0F, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h0204, 1'b0},
        '{8'h04, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3, 1'b0, 16'h0000, 16'h0F0F, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h1F3F, 1'b0},
        '{8'h04, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0, 16'h0000, 16'h0F0F, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h1D3B, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 16'h8001, 16'h8001, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h8005, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd5, 1'b1, 16'h8001, 16'h8001, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h0002, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd6, 1'b1, 16'h8001, 16'h8001, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h4000, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd7, 1'b1, 16'h0000, 16'h0000, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h1234, 1'b0},
        '{8'h0A, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h1234, 1'b1},
        '{8'h04, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h0F0F, 1'b1},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 16'h5555, 16'h1234, 1'b1},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h0000, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h1235, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 16'hFFFE, 16'hFFFE, 1'b0},
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 16'h0000, 16'h0002, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_out_en = '0;
    logic [7:0]  reg_load_en = '0;
    logic        y_load = 1'b0;
    logic        z_load = 1'b0;
    logic        z_drive = 1'b0;
    logic        a_sel_const = 1'b0;
    logic [2:0]  alu_op = '0;
    logic        imm_drive = 1'b0;
    logic [15:0] imm_data = '0;
    logic [2:0]  obs_sel = '0;
    logic [15:0] obs_data;
    logic [15:0] y_val;
    logic [15:0] z_val;
    logic [15:0] bus_val;
    logic        bus_conflict;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    sbus_datapath u_sbus_datapath (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_out_en   (reg_out_en),
        .reg_load_en  (reg_load_en),
        .y_load       (y_load),
        .z_load       (z_load),
        .z_drive      (z_drive),
        .a_sel_const  (a_sel_const),
        .alu_op       (alu_op),
        .imm_drive    (imm_drive),
        .imm_data     (imm_data),
        .obs_sel      (obs_sel),
        .obs_data     (obs_data),
        .y_val        (y_val),
        .z_val        (z_val),
        .bus_val      (bus_val),
        .bus_conflict (bus_conflict)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        reg_out_en = '0; reg_load_en = '0; y_load = 1'b0; z_load = 1'b0;
        z_drive = 1'b0; a_sel_const = 1'b0; alu_op = '0; imm_drive = 1'b0; imm_data = '0;
    endtask

    task automatic read_reg(input int k, input string tag, input logic [15:0] exp);
        @(negedge clk);
        idle();
        obs_sel = 3'(k);
        #1;
        chk(tag, obs_data, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: state after reset
        for (int k = 0; k < 8; k++) read_reg(k, "R1 reg after reset", 16'h0000);
        chk("R1 Y after reset", y_val, 16'h0000);
        chk("R1 Z after reset", z_val, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: bus and conflict flag each step (R2, R3, R6, R7, R8, R10)
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            reg_out_en = TBL[v].ro; reg_load_en = TBL[v].ri; y_load = TBL[v].yi;
            z_load = TBL[v].zi; z_drive = TBL[v].zo; a_sel_const = TBL[v].sc;
            alu_op = TBL[v].op; imm_drive = TBL[v].io; imm_data = TBL[v].imm;
            #2;
            if (v == 23) begin
                chk("R10 Z writeback with operand driver, bus", bus_val, TBL[v].ebus);
                chk("R10 conflict flag", 16'(bus_conflict), 16'(TBL[v].ec));
            end else if (TBL[v].ec) begin
                chk("R3 priority bus", bus_val, TBL[v].ebus);
                chk("R3 conflict flag", 16'(bus_conflict), 16'h0001);
            end else if (TBL[v].zo) begin
                chk("R6/R7/R8 Z result on bus", bus_val, TBL[v].ebus);
                chk("R2 no conflict", 16'(bus_conflict), 16'h0000);
            end else begin
                chk("R2 bus value", bus_val, TBL[v].ebus);
                chk("R2 no conflict", 16'(bus_conflict), 16'h0000);
            end
        end

        // R4 / R9: register contents after the walk
        read_reg(1, "R4 R1 loaded", 16'h1234);
        read_reg(2, "R4 R2 loaded", 16'h0F0F);
        read_reg(3, "R9 three-step sum in R3", 16'h2143);
        read_reg(0, "R4 R0 untouched", 16'h0000);
        for (int k = 4; k < 8; k++) read_reg(k, "R4 unloaded reg holds", 16'h0000);
        chk("R5 Y kept first operand", y_val, 16'h1234);
        chk("R6 Z holds last result", z_val, 16'h0002);

        // R5: Y reload from immediate
        @(negedge clk);
        imm_drive = 1'b1; imm_data = 16'hA5A5; y_load = 1'b1;
        @(negedge clk);
        idle();
        #1;
        chk("R5 Y loads bus", y_val, 16'hA5A5);

        // R7: constant operand ignores Y
        @(negedge clk);
        imm_drive = 1'b1; imm_data = 16'h0010; z_load = 1'b1; a_sel_const = 1'b1;
        @(negedge clk);
        idle();
        #1;
        chk("R7 constant 4 plus bus", z_val, 16'h0014);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 Y cleared mid-run", y_val, 16'h0000);
        chk("R1 Z cleared mid-run", z_val, 16'h0000);
        read_reg(1, "R1 R1 cleared mid-run", 16'h0000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule